// File: doc/BRIEF.md
# Machine Performance Counter Unit

This unit keeps two 64-bit machine-mode counters for a processor core. One counts retired instructions and the other counts clock cycles. A small inhibit register can freeze either counter. Software reads and writes all three through a CSR port. The core raises a retire strobe in each cycle where an instruction completes. Any CSR write presented in that same cycle belongs to the retiring instruction.

The unit's main job is to order a same-instruction CSR write correctly against the retirement increment. The instruction counter's inhibit bit is sampled as it stood before the instruction's own write. So an instruction that sets the inhibit bit is still counted, and one that clears it is not. An explicit write to the instruction counter replaces its value and cancels that instruction's increment. The written value therefore appears exactly, not plus one.

A width input selects a 32-bit or 64-bit register view. In the 32-bit view, each counter is reached through separate low-half and high-half addresses. In the 64-bit view, a single address covers the full counter and the high-half addresses are inert.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset both counters read zero and the inhibit register reads zero, so the first retired instruction is counted.
- R2: With inhibit bit 2 clear and no write to the instruction counter, each cycle with `retire_i` high raises the instruction counter by one on the next clock. A cycle without retirement leaves it unchanged. The carry propagates across bit 31.
- R3: When inhibit bit 2 is already set at the start of a retiring instruction, that instruction leaves the instruction counter unchanged.
- R4: A write to the inhibit register at address 0x320 takes effect only for later instructions. A retiring instruction that sets bit 2 is still counted. A retiring instruction that clears bit 2 is not counted.
- R5: A write to address 0xB02 replaces the low XLEN bits of the instruction counter. In the 32-bit view the upper half is kept. The written value is not incremented, even when the writing instruction retires.
- R6: In the 32-bit view, a write to address 0xB82 replaces bits 63:32 of the instruction counter with write data bits 31:0. Bits 31:0 of the counter are kept, and the writing instruction's increment is cancelled.
- R7: In the 64-bit view, writes to addresses 0xB80 and 0xB82 change nothing, and reads of those addresses return zero.
- R8: The cycle counter rises by one every clock unless inhibit bit 0 is set or the counter is written in that cycle. A write to bit 0 of the inhibit register governs only the following clocks.
- R9: A write to address 0xB00 replaces the low XLEN bits of the cycle counter with no increment in that cycle. In the 32-bit view, address 0xB80 replaces bits 63:32.
- R10: `csr_rdata_o` combinationally returns the value selected by `csr_addr_i`. In the 64-bit view, 0xB00 and 0xB02 return the full counters. In the 32-bit view they return the low halves, and 0xB80 and 0xB82 return the high halves, each zero-extended. An unmapped address returns zero.
- R11: The inhibit register stores only bit 0 (cycle) and bit 2 (instructions). Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlen64_i | input | 1 | 1 selects the 64-bit register view, 0 the 32-bit view |
| retire_i | input | 1 | An instruction retires this cycle |
| csr_we_i | input | 1 | CSR write strobe from the instruction in this cycle |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data for `csr_addr_i` |
| instret_o | output | 64 | Retired-instruction counter |
| cycle_o | output | 64 | Cycle counter |

## Verification
The bench aims at the ordering corners first:
- An instruction that sets its own inhibit bit must still be counted. A design that applied the write early would drop that count.
- An instruction that clears the inhibit bit must not be counted. Applying the write early would count it one instruction too soon.
- An instruction counter write made by a retiring instruction must read back exactly. Off-by-one logic would show the written value plus one.

The bench also checks the half-word writes in the 32-bit view. A wrong merge would disturb the untouched half. It checks that high-half addresses are dead in the 64-bit view, where a leak would corrupt the upper word. It checks the carry out of bit 31 and the one-clock delay before a cycle-inhibit change takes hold.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_CYC_LO = 12'hB00;
    localparam logic [ADDR_W-1:0] ADDR_INS_LO = 12'hB02;
    localparam logic [ADDR_W-1:0] ADDR_CYC_HI = 12'hB80;
    localparam logic [ADDR_W-1:0] ADDR_INS_HI = 12'hB82;
    localparam logic [ADDR_W-1:0] ADDR_INHIB  = 12'h320;

    // Bit positions inside the inhibit register
    localparam int INH_CY_BIT = 0;
    localparam int INH_IR_BIT = 2;

    typedef struct packed {
        logic cyc_lo;
        logic cyc_hi;
        logic ins_lo;
        logic ins_hi;
        logic inhib;
    } csr_hit_t;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic              xlen64_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output csr_hit_t          rd_hit_o,
    output csr_hit_t          wr_hit_o
);

    csr_hit_t hit;

    always_comb begin
        hit        = '0;
        hit.cyc_lo = (addr_i == ADDR_CYC_LO);
        hit.ins_lo = (addr_i == ADDR_INS_LO);
        hit.cyc_hi = (addr_i == ADDR_CYC_HI) && !xlen64_i;
        hit.ins_hi = (addr_i == ADDR_INS_HI) && !xlen64_i;
        hit.inhib  = (addr_i == ADDR_INHIB);
    end

    assign rd_hit_o = hit;
    assign wr_hit_o = we_i ? hit : '0;

endmodule

// File: rtl/pcu_count_next.sv
module pcu_count_next #(
    parameter int CNT_W = 64
) (
    input  logic             xlen64_i,
    input  logic             adv_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cur_i,
    output logic [CNT_W-1:0] nxt_o
);

    localparam int HALF_W = CNT_W / 2;

    always_comb begin
        nxt_o = cur_i;
        if (wr_lo_i) begin
            if (xlen64_i) nxt_o = wdata_i;
            else          nxt_o[HALF_W-1:0] = wdata_i[HALF_W-1:0];
        end else if (wr_hi_i) begin
            nxt_o[CNT_W-1:HALF_W] = wdata_i[HALF_W-1:0];
        end else if (adv_i) begin
            nxt_o = cur_i + 1'b1;
        end
    end

endmodule

// File: rtl/pcu_read_mux.sv
module pcu_read_mux
    import pcu_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             xlen64_i,
    input  csr_hit_t         hit_i,
    input  logic [CNT_W-1:0] instret_i,
    input  logic [CNT_W-1:0] cycle_i,
    input  logic             inh_ir_i,
    input  logic             inh_cy_i,
    output logic [CNT_W-1:0] rdata_o
);

    localparam int HALF_W = CNT_W / 2;

    function automatic logic [CNT_W-1:0] low_view(input logic [CNT_W-1:0] v, input logic wide);
        return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    endfunction

    always_comb begin
        rdata_o = '0;
        if (hit_i.cyc_lo) rdata_o = low_view(cycle_i, xlen64_i);
        if (hit_i.ins_lo) rdata_o = low_view(instret_i, xlen64_i);
        if (hit_i.cyc_hi) rdata_o = {{HALF_W{1'b0}}, cycle_i[CNT_W-1:HALF_W]};
        if (hit_i.ins_hi) rdata_o = {{HALF_W{1'b0}}, instret_i[CNT_W-1:HALF_W]};
        if (hit_i.inhib) begin
            rdata_o[INH_CY_BIT] = inh_cy_i;
            rdata_o[INH_IR_BIT] = inh_ir_i;
        end
    end

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              xlen64_i,
    input  logic              retire_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [CNT_W-1:0]  csr_wdata_i,
    output logic [CNT_W-1:0]  csr_rdata_o,
    output logic [CNT_W-1:0]  instret_o,
    output logic [CNT_W-1:0]  cycle_o
);

    typedef struct packed {
        logic [CNT_W-1:0] instret;
        logic [CNT_W-1:0] cycle;
        logic             inh_ir;
        logic             inh_cy;
    } pcu_state_t;

    pcu_state_t state_d, state_q;
    csr_hit_t   rd_hit, wr_hit;
    logic [CNT_W-1:0] ins_nxt, cyc_nxt;
    logic       ins_adv;
    logic       inh_ir, inh_cy;

    assign inh_ir = state_q.inh_ir;
    assign inh_cy = state_q.inh_cy;

    // Increment permission is taken from the inhibit state held before this
    // instruction's own CSR write lands.
    assign ins_adv = retire_i && !state_q.inh_ir;

    pcu_decode u_dec (
        .xlen64_i (xlen64_i),
        .we_i     (csr_we_i),
        .addr_i   (csr_addr_i),
        .rd_hit_o (rd_hit),
        .wr_hit_o (wr_hit)
    );

    pcu_count_next #(.CNT_W(CNT_W)) u_ins_next (
        .xlen64_i (xlen64_i),
        .adv_i    (ins_adv),
        .wr_lo_i  (wr_hit.ins_lo),
        .wr_hi_i  (wr_hit.ins_hi),
        .wdata_i  (csr_wdata_i),
        .cur_i    (state_q.instret),
        .nxt_o    (ins_nxt)
    );

    pcu_count_next #(.CNT_W(CNT_W)) u_cyc_next (
        .xlen64_i (xlen64_i),
        .adv_i    (!state_q.inh_cy),
        .wr_lo_i  (wr_hit.cyc_lo),
        .wr_hi_i  (wr_hit.cyc_hi),
        .wdata_i  (csr_wdata_i),
        .cur_i    (state_q.cycle),
        .nxt_o    (cyc_nxt)
    );

    pcu_read_mux #(.CNT_W(CNT_W)) u_rd (
        .xlen64_i  (xlen64_i),
        .hit_i     (rd_hit),
        .instret_i (state_q.instret),
        .cycle_i   (state_q.cycle),
        .inh_ir_i  (state_q.inh_ir),
        .inh_cy_i  (state_q.inh_cy),
        .rdata_o   (csr_rdata_o)
    );

    always_comb begin
        state_d         = state_q;
        state_d.instret = ins_nxt;
        state_d.cycle   = cyc_nxt;
        if (wr_hit.inhib) begin
            state_d.inh_ir = csr_wdata_i[INH_IR_BIT];
            state_d.inh_cy = csr_wdata_i[INH_CY_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign instret_o = state_q.instret;
    assign cycle_o   = state_q.cycle;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              xlen64_i,
    input logic              retire_i,
    input logic              csr_we_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [CNT_W-1:0]  csr_wdata_i,
    input logic [CNT_W-1:0]  instret_o,
    input logic [CNT_W-1:0]  cycle_o,
    input logic              inh_ir,
    input logic              inh_cy
);

    logic ins_wr, cyc_wr;
    assign ins_wr = csr_we_i && (csr_addr_i == ADDR_INS_LO ||
                                 (csr_addr_i == ADDR_INS_HI && !xlen64_i));
    assign cyc_wr = csr_we_i && (csr_addr_i == ADDR_CYC_LO ||
                                 (csr_addr_i == ADDR_CYC_HI && !xlen64_i));

    // R2
    instret_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i && !ins_wr && !inh_ir |=> instret_o == $past(instret_o) + 1'b1);

    // R2
    instret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !retire_i && !ins_wr |=> $stable(instret_o));

    // R3
    instret_inhib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i && inh_ir && !ins_wr |=> $stable(instret_o));

    // R4
    late_inhib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i && csr_we_i && csr_addr_i == ADDR_INHIB && csr_wdata_i[INH_IR_BIT] && !inh_ir
        |=> instret_o == $past(instret_o) + 1'b1);

    // R5
    instret_wr_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_we_i && csr_addr_i == ADDR_INS_LO && xlen64_i |=> instret_o == $past(csr_wdata_i));

    // R7
    hi_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_we_i && csr_addr_i == ADDR_INS_HI && xlen64_i && !retire_i |=> $stable(instret_o));

    // R8
    cycle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_wr && !inh_cy |=> cycle_o == $past(cycle_o) + 1'b1);

    // R8
    cycle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_wr && inh_cy |=> $stable(cycle_o));

endmodule

bind perf_counter_unit pcu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xlen64_i    (xlen64_i),
    .retire_i    (retire_i),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .instret_o   (instret_o),
    .cycle_o     (cycle_o),
    .inh_ir      (inh_ir),
    .inh_cy      (inh_cy)
);

// File: tb/perf_counter_unit_tb.sv
`timescale 1ns/1ps
module perf_counter_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlen64 = 1'b1;
    logic        retire = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata, instret, cycle;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    perf_counter_unit u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .xlen64_i    (xlen64),
        .retire_i    (retire),
        .csr_we_i    (csr_we),
        .csr_addr_i  (csr_addr),
        .csr_wdata_i (csr_wdata),
        .csr_rdata_o (csr_rdata),
        .instret_o   (instret),
        .cycle_o     (cycle)
    );

    typedef struct packed {
        logic        ret;
        logic        we;
        logic [11:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    // 64-bit view, cycle counter held frozen (inhibit bit 0 kept set)
    localparam vec_t VEC [14] = '{
        '{1'b1, 1'b0, 12'h000, 64'd0,   64'd1,   8'd1}, // R1 first retire counts
        '{1'b1, 1'b0, 12'h000, 64'd0,   64'd2,   8'd2}, // R2
        '{1'b0, 1'b0, 12'h000, 64'd0,   64'd2,   8'd2}, // R2 no retire holds
        '{1'b1, 1'b1, 12'h320, 64'd5,   64'd3,   8'd4}, // R4 setting IR still counts
        '{1'b1, 1'b0, 12'h000, 64'd0,   64'd3,   8'd3}, // R3 inhibited
        '{1'b1, 1'b1, 12'h320, 64'd1,   64'd3,   8'd4}, // R4 clearing IR not counted
        '{1'b1, 1'b0, 12'h000, 64'd0,   64'd4,   8'd2}, // R2 counting again
        '{1'b1, 1'b1, 12'hB02, 64'd100, 64'd100, 8'd5}, // R5 exact write while retiring
        '{1'b0, 1'b1, 12'hB02, 64'd7,   64'd7,   8'd5}, // R5 write without retire
        '{1'b1, 1'b1, 12'hB82, 64'd55,  64'd8,   8'd7}, // R7 high addr dead in 64-bit view
        '{1'b0, 1'b1, 12'h320, 64'd5,   64'd8,   8'd3}, // R3 set IR, no retire
        '{1'b1, 1'b1, 12'hB02, 64'd20,  64'd20,  8'd5}, // R5 write while inhibited
        '{1'b1, 1'b1, 12'h320, 64'd1,   64'd20,  8'd3}, // R3 inhibit sampled before write
        '{1'b1, 1'b0, 12'h000, 64'd0,   64'd21,  8'd2}  // R2
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic w, input logic [11:0] a, input logic [63:0] d);
        retire = r; csr_we = w; csr_addr = a; csr_wdata = d;
        @(posedge clk);
        #1;
        retire = 1'b0; csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] v, c0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 instret", instret, 64'd0);
        chk("R1 cycle", cycle, 64'd0);
        rd(12'h320, v);
        chk("R1 inhibit", v, 64'd0);

        step(1'b0, 1'b1, 12'h320, 64'd1);
        c0 = cycle;
        foreach (VEC[i]) begin
            step(VEC[i].ret, VEC[i].we, VEC[i].addr, VEC[i].data);
            total++;
            if (instret !== VEC[i].exp) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VEC[i].req, i, instret, VEC[i].exp);
            end
        end
        chk("R8 cycle frozen while inhibited", cycle, c0);

        // R8 clearing cycle inhibit acts from the next clock
        step(1'b0, 1'b1, 12'h320, 64'd0);
        chk("R8 no count in clearing cycle", cycle, c0);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 12'h000, 64'd0);
        chk("R8 free running", cycle, c0 + 64'd5);

        // R9 exact write in 64-bit view, then resume
        step(1'b0, 1'b1, 12'hB00, 64'h0123_4567_89AB_CDEF);
        chk("R9 cycle write", cycle, 64'h0123_4567_89AB_CDEF);
        step(1'b0, 1'b0, 12'h000, 64'd0);
        chk("R9 cycle resumes", cycle, 64'h0123_4567_89AB_CDF0);

        // R11 only bits 0 and 2 stored
        step(1'b0, 1'b1, 12'h320, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h320, v);
        chk("R11 inhibit readback", v, 64'd5);
        step(1'b0, 1'b1, 12'h320, 64'd1);

        // 32-bit view
        xlen64 = 1'b0;
        step(1'b1, 1'b1, 12'hB82, 64'hFFFF_0000_AAAA_BBBB);
        chk("R6 high write keeps low, no bump", instret, 64'hAAAA_BBBB_0000_0015);
        step(1'b1, 1'b1, 12'hB02, 64'h1234_5678_9ABC_DEF0);
        chk("R5 low write keeps high, no bump", instret, 64'hAAAA_BBBB_9ABC_DEF0);
        rd(12'hB02, v);
        chk("R10 instret low half", v, 64'h0000_0000_9ABC_DEF0);
        rd(12'hB82, v);
        chk("R10 instret high half", v, 64'h0000_0000_AAAA_BBBB);
        step(1'b0, 1'b1, 12'hB02, 64'hFFFF_FFFF);
        step(1'b1, 1'b0, 12'h000, 64'd0);
        chk("R2 carry across bit 31", instret, 64'hAAAA_BBBC_0000_0000);

        step(1'b0, 1'b1, 12'hB80, 64'h11);
        step(1'b0, 1'b1, 12'hB00, 64'h22);
        chk("R9 cycle halves", cycle, 64'h0000_0011_0000_0022);
        rd(12'hB80, v);
        chk("R10 cycle high half", v, 64'h11);
        rd(12'hB00, v);
        chk("R10 cycle low half", v, 64'h22);
        rd(12'h123, v);
        chk("R10 unmapped", v, 64'd0);

        // back to 64-bit view
        xlen64 = 1'b1;
        rd(12'hB82, v);
        chk("R7 high read zero", v, 64'd0);
        rd(12'hB02, v);
        chk("R10 full instret", v, 64'hAAAA_BBBC_0000_0000);
        step(1'b0, 1'b1, 12'hB80, 64'h77);
        chk("R7 cycle high write ignored", cycle, 64'h0000_0011_0000_0022);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule